// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters for a host. The line idles at 1. A character starts with a 0 start bit, followed by 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop bit. Bit timing comes from a receive tick, which is a one-cycle strobe in the system clock domain. The tick runs at 1, 16 or 64 times the bit rate. At the higher rates the receiver confirms a start bit at its middle and then samples every later bit at its middle. At the 1x rate it samples once per tick.

Each finished character goes into a holding register, zero-extended to 8 bits, and a ready flag is raised for the host. Parity, framing and overrun faults are recorded in sticky flags that only an explicit clear pulse resets. Reception carries on while these flags are set. A separate detector reports a break when the line stays low for two full character times.

Top module: `serial_rx_core`

## Requirements
- R1: After synchronous reset, `rx_data` is 0 and `rx_ready`, `parity_err`, `framing_err`, `overrun_err` and `break_det` are all 0.
- R2: With `fmt_rate`=1 (16 ticks per bit), `fmt_width`=3 (8 bits) and no parity, a frame sent least significant bit first appears on `rx_data` with `rx_ready` set and no error flag.
- R3: `fmt_width` selects 5+`fmt_width` data bits. A shorter character is delivered with the unused high-order bits of `rx_data` at 0. `fmt_rate`=0 samples one bit per tick, starting at the tick that first sees the line low.
- R4: With `fmt_par_en`=1, the parity bit is expected to make the total count of ones even (`fmt_par_odd`=0) or odd (`fmt_par_odd`=1). A mismatch sets `parity_err`, and the character is still delivered. `fmt_rate`=2 or 3 means 64 ticks per bit.
- R5: A 0 sampled in the stop-bit position sets `framing_err`, and the character is still delivered.
- R6: At 16 or 64 ticks per bit, the line is checked again half a bit after the falling edge. If it is high by then, the receiver returns to idle with no character and no flag.
- R7: Only one stop bit is checked. A start bit that follows a single stop bit directly is received correctly.
- R8: A pulse on `host_read` clears `rx_ready`.
- R9: A character that completes while `rx_ready` is still set replaces the held one and sets `overrun_err`. Characters keep being received while any error flag is set.
- R10: A pulse on `err_clear` clears all three error flags and leaves `rx_ready` and `rx_data` unchanged.
- R11: While `rx_enable` is 0, a character that completes is dropped. `rx_ready`, `rx_data` and the flags do not change.
- R12: `break_det` rises once the line has been low for 2×(2+bits+parity) bit times and falls once the line is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| rx_tick | input | 1 | One-cycle receive tick at 1, 16 or 64 times the bit rate |
| fmt_width | input | 2 | Data bits minus 5 |
| fmt_par_en | input | 1 | Parity bit present |
| fmt_par_odd | input | 1 | 1 = odd parity, 0 = even |
| fmt_rate | input | 2 | 0 = 1x, 1 = 16x, 2/3 = 64x ticks per bit |
| rx_enable | input | 1 | Accept completed characters |
| err_clear | input | 1 | Pulse that clears the error flags |
| host_read | input | 1 | Pulse that marks the held character as read |
| rx_data | output | 8 | Last accepted character, zero-extended |
| rx_ready | output | 1 | Unread character present |
| parity_err | output | 1 | Sticky parity fault |
| framing_err | output | 1 | Sticky stop-bit fault |
| overrun_err | output | 1 | Sticky overwrite fault |
| break_det | output | 1 | Line held low for two character times |

## Verification
The assertions assume that `rx_tick` comes no more often than every other system clock, so that a line change has passed the two synchronizer flops before the next tick samples it. They also assume the format inputs stay fixed while a frame is in flight. The stimulus produces a tick every fourth clock and changes the line only on the falling clock edge just after a tick. It changes the format only while the line is idle, between frames.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    parameter int DATA_W = 8;
    parameter int CNT_W  = 7;
    parameter int BRK_W  = 12;
    localparam int IDX_W = $clog2(DATA_W);
    localparam int NB_W  = IDX_W + 1;

    typedef struct packed {
        logic [1:0] width;
        logic       par_en;
        logic       par_odd;
        logic [1:0] rate;
    } rx_fmt_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_bad;
        logic              stop_bad;
    } rx_frame_t;

    function automatic int rate_ticks(input logic [1:0] rate);
        case (rate)
            2'd0:    return 1;
            2'd1:    return 16;
            default: return 64;
        endcase
    endfunction

    function automatic logic [NB_W-1:0] char_bits(input logic [1:0] width);
        return NB_W'(5 + int'(width));
    endfunction

    function automatic logic [BRK_W-1:0] brk_limit(input rx_fmt_t f);
        int bits;
        bits = 2 + 5 + int'(f.width) + int'(f.par_en);
        return BRK_W'(2 * bits * rate_ticks(f.rate));
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_s
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            line_s <= 1'b1;
        end else begin
            meta_q <= line_in;
            line_s <= meta_q;
        end
    end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      line_s,
    input  rx_fmt_t   fmt,
    output logic      done,
    output rx_frame_t frame
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    rx_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  shreg;
    logic               acc, par_bad, prev_s;
    logic [CNT_W-1:0]   full, half;
    logic [NB_W-1:0]    nbits;
    logic               smp, hsmp, last_bit;

    always_comb begin
        full     = CNT_W'(rate_ticks(fmt.rate));
        half     = full >> 1;
        nbits    = char_bits(fmt.width);
        smp      = tick && (cnt == full - CNT_ONE);
        hsmp     = tick && (cnt == half - CNT_ONE);
        last_bit = ({1'b0, idx} == nbits - NB_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            acc     <= 1'b0;
            par_bad <= 1'b0;
            prev_s  <= 1'b1;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) prev_s <= line_s;
            case (state)
                ST_IDLE: if (tick && prev_s && !line_s) begin
                    cnt     <= '0;
                    idx     <= '0;
                    acc     <= 1'b0;
                    par_bad <= 1'b0;
                    state   <= (fmt.rate == 2'd0) ? ST_DATA : ST_START;
                end
                ST_START: if (hsmp) begin
                    cnt   <= '0;
                    state <= line_s ? ST_IDLE : ST_DATA;
                end else if (tick) cnt <= cnt + CNT_ONE;
                ST_DATA: if (smp) begin
                    cnt   <= '0;
                    shreg <= {line_s, shreg[DATA_W-1:1]};
                    acc   <= acc ^ line_s;
                    if (last_bit) state <= fmt.par_en ? ST_PAR : ST_STOP;
                    else          idx   <= idx + IDX_W'(1);
                end else if (tick) cnt <= cnt + CNT_ONE;
                ST_PAR: if (smp) begin
                    cnt     <= '0;
                    par_bad <= (line_s != (acc ^ fmt.par_odd));
                    state   <= ST_STOP;
                end else if (tick) cnt <= cnt + CNT_ONE;
                ST_STOP: if (smp) begin
                    cnt            <= '0;
                    done           <= 1'b1;
                    frame.data     <= shreg >> (NB_W'(DATA_W) - nbits);
                    frame.par_bad  <= par_bad;
                    frame.stop_bad <= !line_s;
                    state          <= ST_IDLE;
                end else if (tick) cnt <= cnt + CNT_ONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && hsmp && line_s) |=> (state == ST_IDLE && !done));

    // R3
    bit_index_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> ({1'b0, idx} < nbits));

    // R5
    stop_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && smp) |=> (done && frame.stop_bad == !$past(line_s)));
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              rx_enable,
    input  logic              err_clear,
    input  logic              host_read,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q,
    output logic              pe_q,
    output logic              fe_q,
    output logic              oe_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ready_q <= 1'b0;
            pe_q    <= 1'b0;
            fe_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            if (host_read) ready_q <= 1'b0;
            if (err_clear) begin
                pe_q <= 1'b0;
                fe_q <= 1'b0;
                oe_q <= 1'b0;
            end
            if (done && rx_enable) begin
                data_q  <= frame.data;
                ready_q <= 1'b1;
                if (frame.par_bad)          pe_q <= 1'b1;
                if (frame.stop_bad)         fe_q <= 1'b1;
                if (ready_q && !host_read)  oe_q <= 1'b1;
            end
        end
    end

    // R8
    ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_q) |-> $past(host_read));

    // R10
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(pe_q) || $fell(fe_q) || $fell(oe_q)) |-> $past(err_clear));

    // R9
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rx_enable && ready_q && !host_read) |=> oe_q);

    // R11
    drop_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !rx_enable && !err_clear && !host_read) |=>
            ($stable(data_q) && $stable(ready_q) && $stable(pe_q) && $stable(fe_q) && $stable(oe_q)));
endmodule

// File: rtl/serial_rx_break.sv
module serial_rx_break
    import serial_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    line_s,
    input  rx_fmt_t fmt,
    output logic    brk
);
    logic [BRK_W-1:0] low_cnt, limit;

    always_comb limit = brk_limit(fmt);

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            brk     <= 1'b0;
        end else if (line_s) begin
            low_cnt <= '0;
            brk     <= 1'b0;
        end else if (tick) begin
            if (low_cnt >= limit - BRK_W'(1)) brk <= 1'b1;
            else                              low_cnt <= low_cnt + BRK_W'(1);
        end
    end

    // R12
    break_clear_chk: assert property (@(posedge clk) disable iff (rst)
        line_s |=> !brk);

    // R12
    break_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(brk) |-> ($past(!line_s) && $past(tick)));
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serial_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_serial,
    input  logic       rx_tick,
    input  logic [1:0] fmt_width,
    input  logic       fmt_par_en,
    input  logic       fmt_par_odd,
    input  logic [1:0] fmt_rate,
    input  logic       rx_enable,
    input  logic       err_clear,
    input  logic       host_read,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       parity_err,
    output logic       framing_err,
    output logic       overrun_err,
    output logic       break_det
);
    rx_fmt_t   fmt;
    rx_frame_t frame;
    logic      line_s, done;

    always_comb begin
        fmt.width   = fmt_width;
        fmt.par_en  = fmt_par_en;
        fmt.par_odd = fmt_par_odd;
        fmt.rate    = fmt_rate;
    end

    serial_rx_sync u_sync (
        .clk(clk), .rst(rst), .line_in(rx_serial), .line_s(line_s)
    );

    serial_rx_frame u_frame (
        .clk(clk), .rst(rst), .tick(rx_tick), .line_s(line_s),
        .fmt(fmt), .done(done), .frame(frame)
    );

    serial_rx_hold u_hold (
        .clk(clk), .rst(rst), .done(done), .frame(frame),
        .rx_enable(rx_enable), .err_clear(err_clear), .host_read(host_read),
        .data_q(rx_data), .ready_q(rx_ready), .pe_q(parity_err),
        .fe_q(framing_err), .oe_q(overrun_err)
    );

    serial_rx_break u_break (
        .clk(clk), .rst(rst), .tick(rx_tick), .line_s(line_s),
        .fmt(fmt), .brk(break_det)
    );
endmodule

// File: tb/serial_rx_core_test.sv
module serial_rx_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_serial = 1'b1;
    logic       rx_tick = 1'b0;
    logic [1:0] fmt_width = 2'd3;
    logic       fmt_par_en = 1'b0;
    logic       fmt_par_odd = 1'b0;
    logic [1:0] fmt_rate = 2'd1;
    logic       rx_enable = 1'b1;
    logic       err_clear = 1'b0;
    logic       host_read = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, parity_err, framing_err, overrun_err, break_det;

    int checks = 0;
    int failures = 0;
    int tick_div = 0;

    serial_rx_core uut (
        .clk(clk), .rst(rst), .rx_serial(rx_serial), .rx_tick(rx_tick),
        .fmt_width(fmt_width), .fmt_par_en(fmt_par_en), .fmt_par_odd(fmt_par_odd),
        .fmt_rate(fmt_rate), .rx_enable(rx_enable), .err_clear(err_clear),
        .host_read(host_read), .rx_data(rx_data), .rx_ready(rx_ready),
        .parity_err(parity_err), .framing_err(framing_err),
        .overrun_err(overrun_err), .break_det(break_det)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
        rx_tick  <= (tick_div == 3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (rx_tick !== 1'b1);
        end
    endtask

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        rx_serial = v;
        wait_ticks(n);
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input int nb, input int dv,
                              input bit pen, input bit podd, input bit flip, input logic stopv);
        logic [7:0] m;
        m = b & 8'((1 << nb) - 1);
        drive(1'b0, dv);
        for (int i = 0; i < nb; i++) drive(b[i], dv);
        if (pen) drive((^m) ^ podd ^ flip, dv);
        drive(stopv, dv);
    endtask

    task automatic set_fmt(input logic [1:0] w, input bit pen, input bit podd, input logic [1:0] r);
        @(negedge clk);
        fmt_width = w; fmt_par_en = pen; fmt_par_odd = podd; fmt_rate = r;
    endtask

    task automatic clean_up;
        pulse(err_clear);
        pulse(host_read);
    endtask

    task automatic t_reset;
        chk("R1 data", rx_data, 0);
        chk("R1 ready", rx_ready, 0);
        chk("R1 flags", {parity_err, framing_err, overrun_err}, 0);
        chk("R1 break", break_det, 0);
    endtask

    task automatic t_basic16;
        set_fmt(2'd3, 0, 0, 2'd1);
        drive(1'b1, 4);
        send_frame(8'hA5, 8, 16, 0, 0, 0, 1'b1);
        drive(1'b1, 3);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 ready", rx_ready, 1);
        chk("R2 flags", {parity_err, framing_err, overrun_err}, 0);
        pulse(host_read);
        chk("R8 ready cleared", rx_ready, 0);
    endtask

    task automatic t_x1_short;
        set_fmt(2'd0, 1, 0, 2'd0);
        drive(1'b1, 4);
        send_frame(8'h35, 5, 1, 1, 0, 0, 1'b1);
        drive(1'b1, 3);
        chk("R3 data zero-extended", rx_data, 8'h15);
        chk("R3 no parity fault", parity_err, 0);
        chk("R3 ready", rx_ready, 1);
        clean_up();
    endtask

    task automatic t_parity64;
        set_fmt(2'd2, 1, 1, 2'd2);
        drive(1'b1, 4);
        send_frame(8'h5A, 7, 64, 1, 1, 1, 1'b1);
        drive(1'b1, 3);
        chk("R4 parity fault", parity_err, 1);
        chk("R4 data kept", rx_data, 8'h5A);
        clean_up();
        send_frame(8'h2B, 7, 64, 1, 1, 0, 1'b1);
        drive(1'b1, 3);
        chk("R4 good parity", parity_err, 0);
        chk("R4 good data", rx_data, 8'h2B);
        clean_up();
    endtask

    task automatic t_framing;
        set_fmt(2'd3, 0, 0, 2'd1);
        drive(1'b1, 4);
        send_frame(8'h3C, 8, 16, 0, 0, 0, 1'b0);
        drive(1'b1, 3);
        chk("R5 framing fault", framing_err, 1);
        chk("R5 data kept", rx_data, 8'h3C);
        clean_up();
    endtask

    task automatic t_false_start;
        drive(1'b1, 4);
        drive(1'b0, 3);
        drive(1'b1, 40);
        chk("R6 no char", rx_ready, 0);
        chk("R6 no flag", {parity_err, framing_err, overrun_err}, 0);
        send_frame(8'h81, 8, 16, 0, 0, 0, 1'b1);
        drive(1'b1, 3);
        chk("R6 next char ok", rx_data, 8'h81);
        clean_up();
    endtask

    task automatic t_back_to_back;
        drive(1'b1, 4);
        send_frame(8'h11, 8, 16, 0, 0, 0, 1'b1);
        send_frame(8'h22, 8, 16, 0, 0, 0, 1'b1);
        drive(1'b1, 3);
        chk("R7 second char", rx_data, 8'h22);
        chk("R7 no framing fault", framing_err, 0);
        chk("R9 overrun set", overrun_err, 1);
        send_frame(8'h33, 8, 16, 0, 0, 0, 1'b1);
        drive(1'b1, 3);
        chk("R9 runs with flags set", rx_data, 8'h33);
        pulse(err_clear);
        chk("R10 flags cleared", {parity_err, framing_err, overrun_err}, 0);
        chk("R10 ready kept", rx_ready, 1);
        chk("R10 data kept", rx_data, 8'h33);
        pulse(host_read);
    endtask

    task automatic t_disabled;
        @(negedge clk) rx_enable = 1'b0;
        drive(1'b1, 4);
        send_frame(8'h77, 8, 16, 0, 0, 0, 1'b0);
        drive(1'b1, 3);
        chk("R11 ready unchanged", rx_ready, 0);
        chk("R11 data unchanged", rx_data, 8'h33);
        chk("R11 flags unchanged", framing_err, 0);
        @(negedge clk) rx_enable = 1'b1;
    endtask

    task automatic t_break;
        drive(1'b1, 4);
        drive(1'b0, 300);
        chk("R12 not yet", break_det, 0);
        wait_ticks(30);
        @(negedge clk);
        chk("R12 break set", break_det, 1);
        drive(1'b1, 2);
        @(negedge clk);
        chk("R12 break cleared", break_det, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic16();
        t_x1_short();
        t_parity64();
        t_framing();
        t_false_start();
        t_back_to_back();
        t_disabled();
        t_break();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule